// File: doc/BRIEF.md
# Power-Up Clock Source Detector and Selector

This block decides once, right after power-on reset, which clock drives the converter core. During a fixed measurement window timed by the internal oscillator it counts rising edges seen on the external clock pin. If the edge count shows a frequency above a minimum, the external source is chosen. Otherwise the internal oscillator stays in use. A grounded, non-toggling pin therefore always leads to the internal oscillator.

The switch between sources is glitch-free. The gate of the old clock is closed on that clock's low phase before the gate of the new clock opens on the new clock's low phase. Once the switch is confirmed, a valid flag rises and the core reset is released through a synchroniser on the core clock. When the external source wins, the internal oscillator is then shut down. After the decision, a standby request turns off every oscillator except the crystal amplifier, and the crystal amplifier stays on only when the external source is the one in use. The oscillator cells and the gating cell are modelled behaviourally.

Top module: `clk_src_select`

## Requirements
- R1: While power-on reset is low, and after its release until the valid flag rises, the outputs hold these values: valid flag 0, core reset asserted (low), internal-oscillator enable 1 and crystal-amplifier enable 1. While reset is low the select output is also 0.
- R2: After reset release the block counts synchronised rising edges of the external pin over `WINDOW` internal-clock cycles. It selects the external source (select output 1) only when the count exceeds floor(`EXT_MIN_HZ`×`WINDOW`/`INT_FREQ_HZ`), which is 19 at the defaults. Valid never rises before `WINDOW` internal-clock cycles have passed. At the defaults, 1 MHz and 500 kHz select the external source, and 200 kHz and 100 kHz select the internal oscillator.
- R3: A pin held at 0 throughout the window selects the internal oscillator (select output 0).
- R4: When the external source is selected, the core clock after valid runs at the external pin's rate, and the internal-oscillator enable is 0.
- R5: The internal and external clock gates are never open at the same time. The core clock never shows a high or low phase shorter than the shorter half-period of the two sources.
- R6: The valid flag rises only after the chosen gate is confirmed open and the other gate is closed. The core reset is released within a few core-clock edges after valid rises.
- R7: The decision is made once: pin activity that starts after the decision does not change the select output or the core clock.
- R8: Before the decision a standby request is ignored and both oscillator enables stay 1. After the decision, standby with the internal source drives both enables to 0 and stops the core clock. Standby with the external source keeps the crystal-amplifier enable at 1 and the internal-oscillator enable at 0. Outside standby, the crystal-amplifier enable equals the select output.
- R9: Asserting power-on reset at any time returns the block to the R1 state at once, and a new detection runs after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int_i | input | 1 | Internal oscillator clock (stops when its enable is low) |
| ext_clk_i | input | 1 | External clock / crystal pin |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| standby_i | input | 1 | Standby request |
| int_osc_en_o | output | 1 | Internal oscillator enable |
| xtal_osc_en_o | output | 1 | Crystal amplifier enable |
| sel_ext_o | output | 1 | Decision: 1 = external source |
| clk_valid_o | output | 1 | Switchover complete, core clock usable |
| core_rst_no | output | 1 | Core reset, active low, synchronous to core clock |
| core_clk_o | output | 1 | Gated, glitch-free core clock |

## Verification
The detector is tried with a grounded pin and with pin rates of 100 kHz, 200 kHz, 500 kHz and 1 MHz. The two lower rates fall clearly under the threshold and the two higher ones clearly over it, so a comparison with the wrong sign, a wrong threshold or a broken edge counter flips at least one decision. The grounded case separates "no edges" from "slow edges". In each case, standby is applied before and after the decision, which shows whether the request is wrongly honoured during detection and whether each source gets its own power-down rule. A pin that starts toggling after an internal-source decision shows whether the detection ever re-runs. The core clock's edge rate and its shortest phase show which gate is open and whether the switchover glitches.

// File: rtl/clk_src_select_pkg.sv
package clk_src_select_pkg;

  typedef enum logic [1:0] {
    CS_MEASURE = 2'd0,
    CS_SWITCH  = 2'd1,
    CS_DONE    = 2'd2
  } cs_state_e;

endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/cs_bit_sync.sv
module cs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cs_freq_meter.sv
module cs_freq_meter #(
  parameter int WINDOW      = 256,
  parameter int THR_CNT     = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic done_o,
  output logic present_o
);

  localparam int CW = $clog2(WINDOW + 1);

  logic          pin_s;
  logic          pin_prev_q;
  logic          rise;
  logic          win_end;
  logic [CW-1:0] win_q, win_d;
  logic [CW-1:0] edge_q, edge_d;

  cs_bit_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  assign rise    = pin_s & ~pin_prev_q;
  assign win_end = (win_q == CW'(WINDOW));

  always_comb begin
    win_d  = win_q;
    edge_d = edge_q;
    if (!win_end) begin
      win_d = win_q + 1'b1;
      if (rise) begin
        edge_d = edge_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_prev_q <= 1'b0;
      win_q      <= '0;
      edge_q     <= '0;
    end else begin
      pin_prev_q <= pin_s;
      win_q      <= win_d;
      edge_q     <= edge_d;
    end
  end

  assign done_o    = win_end;
  assign present_o = (edge_q > CW'(THR_CNT));

  // A rising edge needs a low sample before it, so at most one edge per two cycles.
  logic [CW:0] edge_cap;
  assign edge_cap = ({1'b0, win_q} + (CW+1)'(1)) >> 1;

  assert_edge_rate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, edge_q} <= edge_cap));

endmodule

// File: rtl/cs_gf_mux.sv
module cs_gf_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_a_i,
  input  logic rst_a_ni,
  input  logic clk_b_i,
  input  logic rst_b_ni,
  input  logic sel_b_i,
  output logic en_a_o,
  output logic en_b_o,
  output logic en_b_seen_a_o,
  output logic clk_o
);

  logic sel_b_s;
  logic en_a_q, en_a_d;
  logic en_b_q, en_b_d;
  logic en_a_seen_b;
  logic en_b_seen_a;

  cs_bit_sync #(.STAGES(SYNC_STAGES)) u_sel_to_b (
    .clk_i (clk_b_i), .rst_ni (rst_b_ni), .d_i (sel_b_i), .q_o (sel_b_s)
  );

  cs_bit_sync #(.STAGES(SYNC_STAGES)) u_ena_to_b (
    .clk_i (clk_b_i), .rst_ni (rst_b_ni), .d_i (en_a_q), .q_o (en_a_seen_b)
  );

  cs_bit_sync #(.STAGES(SYNC_STAGES)) u_enb_to_a (
    .clk_i (clk_a_i), .rst_ni (rst_a_ni), .d_i (en_b_q), .q_o (en_b_seen_a)
  );

  // Each gate opens only once the other gate is seen closed.
  assign en_a_d = ~sel_b_i & ~en_b_seen_a;
  assign en_b_d = sel_b_s & ~en_a_seen_b;

  // Gates change on their own clock's falling edge, while that clock is low.
  always_ff @(negedge clk_a_i or negedge rst_a_ni) begin
    if (!rst_a_ni) begin
      en_a_q <= 1'b0;
    end else begin
      en_a_q <= en_a_d;
    end
  end

  always_ff @(negedge clk_b_i or negedge rst_b_ni) begin
    if (!rst_b_ni) begin
      en_b_q <= 1'b0;
    end else begin
      en_b_q <= en_b_d;
    end
  end

  assign clk_o         = (clk_a_i & en_a_q) | (clk_b_i & en_b_q);
  assign en_a_o        = en_a_q;
  assign en_b_o        = en_b_q;
  assign en_b_seen_a_o = en_b_seen_a;

  assert_b_gate_needs_sel_R4: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    en_b_q |-> sel_b_s);

endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
  import clk_src_select_pkg::*;
#(
  parameter int INT_FREQ_HZ = 4_000_000,
  parameter int EXT_MIN_HZ  = 300_000,
  parameter int WINDOW      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int_i,
  input  logic ext_clk_i,
  input  logic por_ni,
  input  logic standby_i,
  output logic int_osc_en_o,
  output logic xtal_osc_en_o,
  output logic sel_ext_o,
  output logic clk_valid_o,
  output logic core_rst_no,
  output logic core_clk_o
);

  localparam longint THR_L   = (longint'(EXT_MIN_HZ) * longint'(WINDOW)) / longint'(INT_FREQ_HZ);
  localparam int     THR_CNT = int'(THR_L);

  logic      rst_int_n;
  logic      rst_ext_n;
  logic      meas_done;
  logic      ext_present;
  logic      en_a, en_b, en_b_seen;
  logic      handshake_ok;
  cs_state_e state_q, state_d;
  logic      sel_q, sel_d;
  logic      valid_q, valid_d;
  logic      in_done;

  cs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_int (
    .clk_i (clk_int_i), .arst_ni (por_ni), .rst_no (rst_int_n)
  );

  cs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_ext (
    .clk_i (ext_clk_i), .arst_ni (por_ni), .rst_no (rst_ext_n)
  );

  cs_freq_meter #(
    .WINDOW      (WINDOW),
    .THR_CNT     (THR_CNT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_meter (
    .clk_i     (clk_int_i),
    .rst_ni    (rst_int_n),
    .pin_i     (ext_clk_i),
    .done_o    (meas_done),
    .present_o (ext_present)
  );

  cs_gf_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_a_i       (clk_int_i),
    .rst_a_ni      (rst_int_n),
    .clk_b_i       (ext_clk_i),
    .rst_b_ni      (rst_ext_n),
    .sel_b_i       (sel_q),
    .en_a_o        (en_a),
    .en_b_o        (en_b),
    .en_b_seen_a_o (en_b_seen),
    .clk_o         (core_clk_o)
  );

  assign handshake_ok = sel_q ? (en_b_seen & ~en_a) : en_a;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    valid_d = valid_q;
    unique case (state_q)
      CS_MEASURE: begin
        if (meas_done) begin
          sel_d   = ext_present;
          state_d = CS_SWITCH;
        end
      end
      CS_SWITCH: begin
        if (handshake_ok) begin
          valid_d = 1'b1;
          state_d = CS_DONE;
        end
      end
      CS_DONE: begin
        state_d = CS_DONE;
      end
      default: begin
        state_d = CS_MEASURE;
      end
    endcase
  end

  always_ff @(posedge clk_int_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= CS_MEASURE;
      sel_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      valid_q <= valid_d;
    end
  end

  // Core reset released on the core clock once the switchover is confirmed.
  cs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_core (
    .clk_i (core_clk_o), .arst_ni (valid_q), .rst_no (core_rst_no)
  );

  assign in_done       = (state_q == CS_DONE);
  assign int_osc_en_o  = ~in_done | (~sel_q & ~standby_i);
  assign xtal_osc_en_o = ~in_done | sel_q;
  assign sel_ext_o     = sel_q;
  assign clk_valid_o   = valid_q;

  assert_gates_exclusive_R5: assert property (@(posedge clk_int_i) disable iff (!rst_int_n)
    $onehot0({en_a, en_b}));

  assert_decision_held_R7: assert property (@(posedge clk_int_i) disable iff (!rst_int_n)
    ($past(state_q) != CS_MEASURE) |-> $stable(sel_q));

  assert_valid_after_switch_R6: assert property (@(posedge clk_int_i) disable iff (!rst_int_n)
    $rose(valid_q) |-> (sel_q ? (en_b_seen && !en_a) : en_a));

endmodule

// File: tb/clk_src_select_tb.sv
`timescale 1ns/1ps
module clk_src_select_tb;

  localparam int CLK_PERIOD = 250;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int WINDOW     = 256;
  localparam int WATCHDOG   = 150000;

  logic clk_int, ext_clk, por_n, standby, tb_clk;
  logic int_osc_en, xtal_osc_en, sel_ext, clk_valid, core_rst_n, core_clk;

  int  compared = 0, mismatched = 0;
  int  ext_half = 0;
  int  int_cycles = 0, core_edges = 0, tick_total = 0;
  bit  exp_sel = 0, track = 0;
  real last_core_t = 0.0, last_por_t = 0.0;

  clk_src_select #(.WINDOW(WINDOW)) u_dut (
    .clk_int_i (clk_int), .ext_clk_i (ext_clk), .por_ni (por_n), .standby_i (standby),
    .int_osc_en_o (int_osc_en), .xtal_osc_en_o (xtal_osc_en), .sel_ext_o (sel_ext),
    .clk_valid_o (clk_valid), .core_rst_no (core_rst_n), .core_clk_o (core_clk)
  );

  // Behavioural internal oscillator: runs only while enabled.
  initial clk_int = 1'b0;
  always begin
    #(HALF);
    if (int_osc_en) clk_int = ~clk_int;
    else            clk_int = 1'b0;
  end

  initial ext_clk = 1'b0;
  always begin
    if (ext_half == 0) begin ext_clk = 1'b0; #(HALF); end
    else begin #(ext_half); ext_clk = ~ext_clk; end
  end

  // Free sampling clock, offset from every source edge.
  initial begin
    tb_clk = 1'b0;
    #(CLK_PERIOD/4);
    forever #(HALF) tb_clk = ~tb_clk;
  end

  task automatic chk(string req, string what, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic chk_near(string req, string what, int act, int expv, int tol);
    compared++;
    if (act > expv + tol || act < expv - tol) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d+-%0d at %0t", req, what, act, expv, tol, $time);
    end
  endtask

  always @(posedge clk_int) if (por_n) int_cycles++;
  always @(posedge core_clk) core_edges++;
  always @(por_n) last_por_t = $realtime;

  // R5: no shortened phase on the core clock (pulses spanning a reset edge are skipped).
  always @(core_clk) begin
    real t;
    t = $realtime;
    if (por_n && last_core_t > last_por_t) begin
      compared++;
      if (t - last_core_t < real'(HALF - 5)) begin
        mismatched++;
        $display("FAIL R5 core clock phase: actual=%0.1f expected>=%0d at %0t",
                 t - last_core_t, HALF - 5, $time);
      end
    end
    last_core_t = t;
  end

  // Reference model compared on every sampling clock.
  always @(posedge tb_clk) begin
    tick_total++;
    if (tick_total > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", tick_total, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (por_n && track) begin
      if (!clk_valid) begin
        chk("R1", "pre-valid {rst_n,int_en,xtal_en}",
            int'({core_rst_n, int_osc_en, xtal_osc_en}), 3);      // R8: standby ignored here
      end else begin
        chk("R2", "decision", int'(sel_ext), int'(exp_sel));
        chk("R2", "valid not before window", int'(int_cycles >= WINDOW), 1);
        chk("R8", "int osc enable", int'(int_osc_en), int'(!exp_sel && !standby));
        chk("R8", "xtal enable", int'(xtal_osc_en), int'(exp_sel));
      end
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge tb_clk);
  endtask

  task automatic rate_check(string req, int span, int expv);
    core_edges = 0;
    ticks(span);
    chk_near(req, "core clock edges", core_edges, expv, 1);
  endtask

  task automatic scenario(int half_v, bit exp_v, bit sb_in_meas);
    int n;
    int src_half;
    @(negedge tb_clk);
    track   = 0;
    por_n   = 1'b0;
    standby = 1'b0;
    ext_half = half_v;
    exp_sel  = exp_v;
    ticks(1);
    chk("R9", "reset {valid,rst_n,sel,int_en,xtal_en}",
        int'({clk_valid, core_rst_n, sel_ext, int_osc_en, xtal_osc_en}), 3);
    ticks(4);
    int_cycles = 0;
    por_n = 1'b1;
    track = 1;
    if (sb_in_meas) begin
      ticks(20);
      standby = 1'b1;           // R8: must not stop detection
      ticks(60);
      standby = 1'b0;
    end
    n = 0;
    while (!clk_valid && n < 2000) begin ticks(1); n++; end
    chk("R6", "valid rises", int'(clk_valid), 1);
    ticks(20);
    chk("R6", "core reset released", int'(core_rst_n), 1);
    chk(exp_v ? "R2" : "R3", "select", int'(sel_ext), int'(exp_v));
    src_half = exp_v ? half_v : HALF;
    rate_check(exp_v ? "R4" : "R3", 160, (160 * CLK_PERIOD) / (2 * src_half));
    standby = 1'b1;
    ticks(4);
    if (exp_v) rate_check("R8", 40, (40 * CLK_PERIOD) / (2 * src_half));
    else       rate_check("R8", 40, 0);
    standby = 1'b0;
    ticks(4);
    rate_check("R8", 40, (40 * CLK_PERIOD) / (2 * src_half));
    if (!exp_v) begin
      ext_half = 500;           // R7: late pin activity
      ticks(80);
      chk("R7", "select after late pin activity", int'(sel_ext), 0);
      rate_check("R7", 80, 80);
    end
  endtask

  initial begin
    por_n   = 1'b1;
    standby = 1'b0;
    #1 por_n = 1'b0;
    scenario(0,    1'b0, 1'b1);   // grounded pin
    scenario(500,  1'b1, 1'b1);   // 1 MHz
    scenario(1000, 1'b1, 1'b0);   // 500 kHz
    scenario(2500, 1'b0, 1'b1);   // 200 kHz
    scenario(5000, 1'b0, 1'b0);   // 100 kHz
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule